// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Sequencer

This block keeps an asynchronous DRAM alive. Once reset has been released it holds off all activity for a programmable power-up pause. It then drives eight dummy refresh cycles on its own, and only after the last of these has finished does it declare the memory ready. From then on an interval timer raises a refresh request at a fixed period. The period is chosen so that every row is refreshed within the retention time; for a part with 1024 rows and a 16 ms retention time, that means one refresh about every 15.6 µs.

The access controller answers a request with a one-cycle grant. The sequencer then takes the strobes and generates the whole refresh cycle by itself. Two styles are available, chosen per cycle by an input. In CAS-before-RAS, column strobe falls ahead of row strobe and the address bus is not used. In RAS-only, column strobe stays high and an internal 10-bit row counter drives the row address. Refreshes that the controller cannot serve at once are queued up to a configurable depth. A full queue raises an urgent flag.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `init_done`, `ref_req`, `ref_urgent`, `busy` and `addr_en` are low and `ras_n` and `cas_n` are high.
- R2: After reset release no strobe activity occurs for at least INIT_PAUSE_CYC clock cycles, and the first dummy cycle starts no later than 4 cycles after that.
- R3: Exactly DUMMY_CYCLES (8) refresh cycles are issued without any grant. `init_done` rises in the cycle after the last of them completes and stays high until reset.
- R4: In CAS-before-RAS mode (`ras_only_sel` = 0), `cas_n` is low for at least LEAD_CYC cycles before `ras_n` falls and stays low while `ras_n` is low, and `addr_en` stays low.
- R5: In RAS-only mode (`ras_only_sel` = 1), `cas_n` stays high throughout the cycle. `addr_en` is high for at least one cycle before `ras_n` falls and remains high while `ras_n` is low, with `row_addr` stable.
- R6: Every refresh cycle holds `ras_n` low for exactly RAS_CYC cycles, and `ras_n` stays high for at least RP_CYC cycles between two cycles.
- R7: The row address starts at 0 after reset. It advances by one after each completed RAS-only cycle and wraps from 1023 to 0. CAS-before-RAS cycles leave it unchanged.
- R8: After `init_done` rises, a refresh is queued every REF_INTERVAL cycles. The first one makes `ref_req` visible exactly REF_INTERVAL cycles after `init_done` is first visible.
- R9: A grant sampled while `ref_req` is high starts a refresh cycle at the next clock edge, with `busy` high and `ref_req` low for its duration, and removes one queued refresh. If a new interval expires in the same cycle as a grant is taken, the queue count is left unchanged.
- R10: The queue holds at most MAX_PENDING refreshes; further expiries are dropped. `ref_urgent` is high exactly while the queue is full.
- R11: A grant is ignored while nothing is queued or before `init_done`: no cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_only_sel | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS; sampled at cycle start |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | A refresh is queued and the sequencer is idle |
| ref_urgent | output | 1 | Refresh queue is full |
| busy | output | 1 | A refresh cycle owns the DRAM strobes |
| init_done | output | 1 | Power-up sequence complete; normal access allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_en | output | 1 | Sequencer drives the address bus with `row_addr` |
| row_addr | output | 10 | Refresh row for RAS-only cycles |

## Verification
The interval expiry and the start of a granted refresh can fall on the same clock edge. One adds to the queue count and the other removes from it, so an error here either loses a refresh or invents one. The bench waits for a request to appear, which marks an expiry edge. It then raises the grant exactly one interval later, so that the start coincides with the next expiry. It judges the result from the ports: after that cycle finishes, `ref_req` must be high again without any further expiry, and a single further grant must empty the queue.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_DUMMY = 2'd1,
    PH_RUN   = 2'd2
  } init_phase_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LEAD   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_PRECH  = 2'd3
  } strobe_state_t;

  typedef enum logic {
    MODE_CBR   = 1'b0,
    MODE_RONLY = 1'b1
  } ref_mode_t;

endpackage

// File: rtl/dram_ref_init_ctl.sv
module dram_ref_init_ctl
  import dram_ref_pkg::*;
#(
  parameter int INIT_PAUSE_CYC = 10000,
  parameter int DUMMY_CYCLES   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_done,
  input  logic cyc_start,
  output logic dummy_req,
  output logic init_done
);

  localparam int PW = $clog2(INIT_PAUSE_CYC + 1);
  localparam int DW = $clog2(DUMMY_CYCLES + 1);
  localparam logic [PW-1:0] PAUSE_LOAD = PW'(INIT_PAUSE_CYC - 1);
  localparam logic [DW-1:0] DUMMY_LAST = DW'(DUMMY_CYCLES - 1);

  init_phase_t    phase_q, phase_d;
  logic [PW-1:0]  pause_q, pause_d;
  logic [DW-1:0]  dummy_q, dummy_d;

  always_comb begin
    phase_d = phase_q;
    pause_d = pause_q;
    dummy_d = dummy_q;
    unique case (phase_q)
      PH_PAUSE: begin
        if (pause_q == '0) phase_d = PH_DUMMY;
        else               pause_d = pause_q - 1'b1;
      end
      PH_DUMMY: begin
        if (cyc_done) begin
          if (dummy_q == DUMMY_LAST) phase_d = PH_RUN;
          else                       dummy_d = dummy_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      pause_q <= PAUSE_LOAD;
      dummy_q <= '0;
    end else begin
      phase_q <= phase_d;
      pause_q <= pause_d;
      dummy_q <= dummy_d;
    end
  end

  assign dummy_req = (phase_q == PH_DUMMY);
  assign init_done = (phase_q == PH_RUN);

  p_no_start_in_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAUSE) |-> !cyc_start);

  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_ready_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(cyc_done));

endmodule

// File: rtl/dram_ref_interval.sv
module dram_ref_interval #(
  parameter int REF_INTERVAL = 780,
  parameter int MAX_PENDING  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic take,
  output logic has_pending,
  output logic queue_full
);

  localparam int IW  = $clog2(REF_INTERVAL);
  localparam int PDW = $clog2(MAX_PENDING + 1);
  localparam logic [IW-1:0]  TICK_AT = IW'(REF_INTERVAL - 1);
  localparam logic [PDW-1:0] PEND_MAX = PDW'(MAX_PENDING);

  logic [IW-1:0]  tmr_q, tmr_d;
  logic [PDW-1:0] pend_q, pend_d;
  logic           tick;

  assign tick = run_en && (tmr_q == TICK_AT);

  always_comb begin
    tmr_d = tmr_q;
    if (run_en) begin
      if (tick) tmr_d = '0;
      else      tmr_d = tmr_q + 1'b1;
    end
  end

  always_comb begin
    pend_d = pend_q;
    unique case ({tick, take})
      2'b10: if (pend_q != PEND_MAX) pend_d = pend_q + 1'b1;
      2'b01: pend_d = pend_q - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
    end
  end

  assign has_pending = (pend_q != '0);
  assign queue_full  = (pend_q == PEND_MAX);

  p_pend_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_MAX);

  p_take_needs_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_pending);

  p_collide_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && take) |=> $stable(pend_q));

endmodule

// File: rtl/dram_ref_strobe.sv
module dram_ref_strobe
  import dram_ref_pkg::*;
#(
  parameter int LEAD_CYC = 1,
  parameter int RAS_CYC  = 3,
  parameter int RP_CYC   = 2,
  parameter int ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                ronly_sel,
  output logic                busy,
  output logic                cyc_done,
  output logic                ras_n,
  output logic                cas_n,
  output logic                addr_en,
  output logic [ROW_BITS-1:0] row_addr
);

  localparam int M1   = (LEAD_CYC > RAS_CYC) ? LEAD_CYC : RAS_CYC;
  localparam int MAXC = (M1 > RP_CYC) ? M1 : RP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LEAD_LOAD = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] RAS_LOAD  = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_LOAD   = CW'(RP_CYC - 1);

  strobe_state_t       st_q, st_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  ref_mode_t           mode_q, mode_d;
  logic [ROW_BITS-1:0] row_q, row_d;
  logic                cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_LEAD;
          cnt_d  = LEAD_LOAD;
          mode_d = ronly_sel ? MODE_RONLY : MODE_CBR;
        end
      end
      ST_LEAD: begin
        if (cnt_zero) begin
          st_d  = ST_ACTIVE;
          cnt_d = RAS_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (cnt_zero) begin
          st_d  = ST_PRECH;
          cnt_d = RP_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PRECH: begin
        if (cnt_zero) st_d  = ST_IDLE;
        else          cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cyc_done = (st_q == ST_PRECH) && cnt_zero;

  always_comb begin
    row_d = row_q;
    if (cyc_done && (mode_q == MODE_RONLY)) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= MODE_CBR;
      row_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      row_q  <= row_d;
    end
  end

  logic strobe_phase;
  assign strobe_phase = (st_q == ST_LEAD) || (st_q == ST_ACTIVE);

  assign busy     = (st_q != ST_IDLE);
  assign ras_n    = (st_q != ST_ACTIVE);
  assign cas_n    = !(strobe_phase && (mode_q == MODE_CBR));
  assign addr_en  = strobe_phase && (mode_q == MODE_RONLY);
  assign row_addr = row_q;

  p_cas_leads_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && (mode_q == MODE_CBR)) |-> (!cas_n && $past(!cas_n)));

  p_cas_idle_ronly_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode_q == MODE_RONLY)) |-> cas_n);

  p_addr_leads_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && (mode_q == MODE_RONLY)) |-> (addr_en && $past(addr_en)));

  p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && (mode_q == MODE_RONLY)) |=> (row_addr == $past(row_addr) + 1'b1));

  p_ras_rise_prech_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (st_q == ST_PRECH));

  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_done) |=> busy);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int INIT_PAUSE_CYC = 10000,
  parameter int DUMMY_CYCLES   = 8,
  parameter int REF_INTERVAL   = 780,
  parameter int MAX_PENDING    = 4,
  parameter int LEAD_CYC       = 1,
  parameter int RAS_CYC        = 3,
  parameter int RP_CYC         = 2,
  parameter int ROW_BITS       = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_only_sel,
  input  logic                ref_gnt,
  output logic                ref_req,
  output logic                ref_urgent,
  output logic                busy,
  output logic                init_done,
  output logic                ras_n,
  output logic                cas_n,
  output logic                addr_en,
  output logic [ROW_BITS-1:0] row_addr
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic dummy_req, cyc_done, cyc_start, take, has_pending, queue_full;

  assign take      = !busy && init_done && has_pending && ref_gnt;
  assign cyc_start = !busy && (dummy_req || take);

  dram_ref_init_ctl #(
    .INIT_PAUSE_CYC (INIT_PAUSE_CYC),
    .DUMMY_CYCLES   (DUMMY_CYCLES)
  ) u_init (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cyc_done  (cyc_done),
    .cyc_start (cyc_start),
    .dummy_req (dummy_req),
    .init_done (init_done)
  );

  dram_ref_interval #(
    .REF_INTERVAL (REF_INTERVAL),
    .MAX_PENDING  (MAX_PENDING)
  ) u_interval (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run_en      (init_done),
    .take        (take),
    .has_pending (has_pending),
    .queue_full  (queue_full)
  );

  dram_ref_strobe #(
    .LEAD_CYC (LEAD_CYC),
    .RAS_CYC  (RAS_CYC),
    .RP_CYC   (RP_CYC),
    .ROW_BITS (ROW_BITS)
  ) u_strobe (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (cyc_start),
    .ronly_sel (ras_only_sel),
    .busy      (busy),
    .cyc_done  (cyc_done),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .addr_en   (addr_en),
    .row_addr  (row_addr)
  );

  assign ref_req    = init_done && has_pending && !busy;
  assign ref_urgent = queue_full;

  p_req_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ref_req |-> !busy);

  p_gnt_starts_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ref_req && ref_gnt) |=> (busy && !ras_n == 1'b0));

  p_idle_gnt_ignored_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (init_done && !busy && !ref_req) |=> !busy);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (ras_n && cas_n && !init_done && !ref_req));

endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;

  localparam int PAUSE   = 50;
  localparam int DUMMY   = 8;
  localparam int INTV    = 40;
  localparam int MAXP    = 3;
  localparam int LEAD    = 1;
  localparam int RASC    = 3;
  localparam int RPC     = 2;
  localparam int RB      = 10;

  logic          clk, rst_n, ras_only_sel, ref_gnt;
  logic          ref_req, ref_urgent, busy, init_done, ras_n, cas_n, addr_en;
  logic [RB-1:0] row_addr;

  int n_tests, n_fail, cyc;

  dram_refresh_seq #(
    .INIT_PAUSE_CYC (PAUSE), .DUMMY_CYCLES (DUMMY), .REF_INTERVAL (INTV),
    .MAX_PENDING (MAXP), .LEAD_CYC (LEAD), .RAS_CYC (RASC), .RP_CYC (RPC),
    .ROW_BITS (RB)
  ) uut (
    .clk (clk), .rst_n (rst_n), .ras_only_sel (ras_only_sel), .ref_gnt (ref_gnt),
    .ref_req (ref_req), .ref_urgent (ref_urgent), .busy (busy),
    .init_done (init_done), .ras_n (ras_n), .cas_n (cas_n), .addr_en (addr_en),
    .row_addr (row_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe monitor: samples on the falling clock edge
  int  falls, hi_len, lo_len, cas_lead, addr_lead, exp_row, ronly_done;
  bit  p_ras, cyc_ronly, seen_rise;
  logic [RB-1:0] fall_row;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      falls = 0; hi_len = 0; lo_len = 0; cas_lead = 0; addr_lead = 0;
      exp_row = 0; ronly_done = 0; p_ras = 1'b1; seen_rise = 1'b0;
    end else begin
      if (p_ras && !ras_n) begin
        falls++;
        lo_len = 1;
        cyc_ronly = cas_n;
        fall_row = row_addr;
        if (seen_rise) chk(hi_len >= RPC, "R6 precharge", hi_len, RPC);
        if (!cas_n) begin
          chk(cas_lead >= LEAD, "R4 cas lead", cas_lead, LEAD);
          chk(!addr_en, "R4 addr_en low", addr_en, 0);
        end else begin
          chk(addr_lead >= 1 && addr_en, "R5 addr lead", addr_lead, 1);
          chk(row_addr == RB'(exp_row), "R7 row value", row_addr, exp_row % 1024);
        end
      end else if (!p_ras && !ras_n) begin
        lo_len++;
        chk(cas_n == cyc_ronly, "R4/R5 cas steady while ras low", cas_n, cyc_ronly);
        if (cyc_ronly) chk(addr_en && row_addr == fall_row, "R5 row stable", row_addr, fall_row);
      end else if (!p_ras && ras_n) begin
        chk(lo_len == RASC, "R6 ras width", lo_len, RASC);
        seen_rise = 1'b1;
        hi_len = 1;
        if (cyc_ronly) begin exp_row = (exp_row + 1) % 1024; ronly_done++; end
      end else begin
        hi_len++;
      end
      cas_lead  = (ras_n && !cas_n) ? cas_lead + 1 : 0;
      addr_lead = (ras_n && addr_en) ? addr_lead + 1 : 0;
      p_ras = ras_n;
    end
  end

  initial begin
    #(20 * 200000);
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic serve_one();
    while (!ref_req) @(negedge clk);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk(busy && !ref_req, "R9 grant starts cycle", busy, 1);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_gnt = 1'b0; ras_only_sel = 1'b0;
    wait_neg(3);
    chk(!init_done && !ref_req && !ref_urgent && !busy && !addr_en, "R1 outputs low",
        {init_done, ref_req, ref_urgent, busy, addr_en}, 0);
    chk(ras_n && cas_n, "R1 strobes high", {ras_n, cas_n}, 3);
  endtask

  task automatic t_init();
    int k;
    ref_gnt = 1'b1; // R11: grant held through init must not matter
    rst_n = 1'b1;
    k = 0;
    while (!busy && k < PAUSE + 20) begin @(negedge clk); k++; end
    chk(k >= PAUSE && k <= PAUSE + 4, "R2 pause length", k, PAUSE);
    while (!init_done && k < PAUSE + 200) begin @(negedge clk); k++; end
    chk(falls == DUMMY && !busy, "R3 dummy count at ready", falls, DUMMY);
    chk(!ref_req, "R11 no request at ready", ref_req, 0);
    ref_gnt = 1'b0;
    wait_neg(3);
    chk(falls == DUMMY && init_done, "R3 no extra cycles", falls, DUMMY);
  endtask

  task automatic t_first_req();
    int k;
    k = 3;
    while (!ref_req && k < INTV + 10) begin @(negedge clk); k++; end
    chk(k == INTV, "R8 first request delay", k, INTV);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk(busy && !ref_req && !cas_n && ras_n, "R9 start next edge (R4 cbr lead)",
        {busy, ref_req, cas_n, ras_n}, 9);
    while (busy) @(negedge clk);
    chk(!ref_req, "R9 queue drained", ref_req, 0);
  endtask

  task automatic t_gnt_ignore();
    int f0;
    f0 = falls;
    ref_gnt = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!busy, "R11 grant without request", busy, 0);
    end
    ref_gnt = 1'b0;
    chk(falls == f0, "R11 no strobe", falls, f0);
  endtask

  task automatic t_queue();
    int served;
    while (!ref_urgent) @(negedge clk);
    chk(ref_req, "R10 request with full queue", ref_req, 1);
    wait_neg(2 * INTV);
    chk(ref_urgent, "R10 stays full", ref_urgent, 1);
    served = 0;
    serve_one(); served++;
    chk(!ref_urgent, "R10 urgent clears after take", ref_urgent, 1'b0);
    while (ref_req) begin serve_one(); served++; @(negedge clk); end
    chk(served == MAXP, "R10 saturating queue depth", served, MAXP);
  endtask

  task automatic t_collide();
    int f0;
    while (!ref_req) @(negedge clk);
    wait_neg(INTV - 1);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk(busy, "R9 collision start", busy, 1);
    while (busy) @(negedge clk);
    chk(ref_req, "R9 collision keeps one queued", ref_req, 1);
    serve_one();
    f0 = falls;
    wait_neg(5);
    chk(!ref_req && falls == f0, "R9 collision queue empty", ref_req, 0);
  endtask

  task automatic t_rasonly();
    int r0;
    ras_only_sel = 1'b1;
    r0 = ronly_done;
    chk(row_addr == 0, "R7 row after cbr cycles", row_addr, 0);
    for (int i = 0; i < 1026; i++) serve_one();
    chk(ronly_done - r0 == 1026, "R5 ras-only cycles seen", ronly_done - r0, 1026);
    chk(row_addr == RB'(2), "R7 wrap to 2 after 1026", row_addr, 2);
    ras_only_sel = 1'b0;
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0;
    t_reset();
    t_init();
    t_first_req();
    t_gnt_ignore();
    t_queue();
    t_collide();
    t_rasonly();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule